// File: doc/BRIEF.md
# Serial Register Control Port with Readback

This block is a serial slave that gives a host write and read access to an array of 16-bit control registers. The host frames each transfer with an active-low chip select and clocks it with a serial clock. A transfer carries 24 bits, most significant bit first: a direction flag (1 = read, 0 = write), a 7-bit register address, and 16 data bits. The serial inputs are brought into the system clock domain through two-stage synchronizers. All framing, shifting and strobing then runs on the system clock, so the serial clock must be slow compared to it.

After a complete write frame, the block issues a one-cycle write strobe together with the address and data. A complete write to address 0 instead issues a soft-reset pulse. No write has any effect while the power-on reset input is active. On a read, the block presents the address to the register array and takes the value back combinationally. It then shifts the value out, one bit per falling serial-clock edge. Address 0 always reads back the fixed identity value 0x8990. The readback pin can be the shared data line, which gives three wires, or a separate output, which gives four. The pin can be driven both ways, or only driven low, with the high level left to a pull-up.

Top module: `spi_regport`

## Requirements
- R1: A complete frame is 24 bits sampled on rising serial-clock edges while `csb` is low: bit 23 is the direction (0 = write), bits 22:16 the address, bits 15:0 the data. After `csb` rises on a complete write frame to a nonzero address, `wr_stb` pulses with `wr_addr` and `wr_data` equal to those fields.
- R2: `wr_stb` and `soft_rst` are never high for more than one consecutive system clock, and never high together.
- R3: A frame ended by `csb` rising after fewer than 24 rising edges produces neither `wr_stb` nor `soft_rst`.
- R4: Rising edges after the 24th in a frame are ignored: the written address and data are those of the first 24 bits.
- R5: In a read frame, `rd_addr` holds the received address from the 8th rising edge. The register value is driven from the falling edge after the 8th rising edge, bit 15 first, with one new bit on each later falling edge.
- R6: A read of address 0 returns 0x8990 whatever `rd_data` holds.
- R7: A complete write frame to address 0 pulses `soft_rst` and does not pulse `wr_stb`.
- R8: While `por_active` is high when the end of a frame is detected, neither `wr_stb` nor `soft_rst` pulses.
- R9: With `cfg_rb3w` = 1, readback uses `sdio_out`/`sdio_oe`. With `cfg_rb3w` = 0, it uses `sdout_out`/`sdout_oe`. The unselected pin's enable stays low.
- R10: With `cfg_odrain` = 0, the selected enable is high for the whole data phase and the out pin carries the bit. With `cfg_odrain` = 1, the out pin is 0 and the enable is high exactly when the bit is 0.
- R11: Both enables are low while `csb` has been high for four system clocks, and throughout write frames.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| por_active | input | 1 | Power-on reset in progress; blocks writes |
| cfg_rb3w | input | 1 | 1 = readback on shared data line, 0 = separate output |
| cfg_odrain | input | 1 | 1 = drive low only, 0 = drive both levels |
| csb | input | 1 | Frame select, active low |
| sclk | input | 1 | Serial clock |
| sdin | input | 1 | Serial data in |
| sdio_out | output | 1 | Shared-line readback value |
| sdio_oe | output | 1 | Shared-line drive enable |
| sdout_out | output | 1 | Separate-pin readback value |
| sdout_oe | output | 1 | Separate-pin drive enable |
| rd_addr | output | 7 | Address presented for a read fetch |
| rd_data | input | 16 | Register value for `rd_addr` |
| wr_stb | output | 1 | One-cycle write strobe |
| wr_addr | output | 7 | Write address |
| wr_data | output | 16 | Write data |
| soft_rst | output | 1 | One-cycle pulse on a write to address 0 |

## Verification
A wrong bit count shows at the ports in one of three ways. A write may appear on a short frame, the written data may be shifted, or the read data may start one bit early or late. All of these can be seen no later than the system clocks after `csb` rises. A stale header or direction flag shows as a missing or spurious strobe, or as a readback driven during a write frame. A wrong readback shift state is visible on the very next falling edge as a bad bit. In drive-low mode it can also show as an enable raised while the value is high.

// File: rtl/spi_regport.sv
module spi_regport #(
  parameter int AW = 7,
  parameter int DW = 16,
  parameter logic [15:0] ID_VAL = 16'h8990
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          por_active,
  input  logic          cfg_rb3w,
  input  logic          cfg_odrain,
  input  logic          csb,
  input  logic          sclk,
  input  logic          sdin,
  output logic          sdio_out,
  output logic          sdio_oe,
  output logic          sdout_out,
  output logic          sdout_oe,
  output logic [AW-1:0] rd_addr,
  input  logic [DW-1:0] rd_data,
  output logic          wr_stb,
  output logic [AW-1:0] wr_addr,
  output logic [DW-1:0] wr_data,
  output logic          soft_rst
);
  localparam int HW = AW + 1;
  localparam int FW = HW + DW;
  localparam int CW = $clog2(FW + 1);

  logic          cs_m, cs_s, sck_m, sck_s, sck_q, sdi_m, sdi_s;
  logic [FW-1:0] sr;
  logic [HW-1:0] hdr;
  logic [CW-1:0] cnt;
  logic [DW-1:0] ob;
  logic          rb_active;
  logic          sck_rise, sck_fall, drv, bit_o, oe_o, out_o;

  assign sck_rise = sck_s & ~sck_q;
  assign sck_fall = ~sck_s & sck_q;
  assign rd_addr  = hdr[AW-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_m <= 1'b1; cs_s <= 1'b1;
      sck_m <= 1'b0; sck_s <= 1'b0; sck_q <= 1'b0;
      sdi_m <= 1'b0; sdi_s <= 1'b0;
      sr <= '0; hdr <= '0; cnt <= '0; ob <= '0; rb_active <= 1'b0;
      wr_stb <= 1'b0; soft_rst <= 1'b0; wr_addr <= '0; wr_data <= '0;
    end else begin
      cs_m <= csb;   cs_s <= cs_m;
      sck_m <= sclk; sck_s <= sck_m; sck_q <= sck_s;
      sdi_m <= sdin; sdi_s <= sdi_m;
      wr_stb <= 1'b0;
      soft_rst <= 1'b0;
      if (cs_s) begin
        if (cnt == CW'(FW) && !sr[FW-1] && !por_active) begin
          if (sr[FW-2 -: AW] == '0) begin
            soft_rst <= 1'b1;
          end else begin
            wr_stb  <= 1'b1;
            wr_addr <= sr[FW-2 -: AW];
            wr_data <= sr[DW-1:0];
          end
        end
        cnt <= '0;
        hdr <= '0;
        rb_active <= 1'b0;
      end else begin
        if (sck_rise && cnt < CW'(FW)) begin
          sr  <= {sr[FW-2:0], sdi_s};
          cnt <= cnt + 1'b1;
          if (cnt == CW'(HW - 1)) hdr <= {sr[HW-2:0], sdi_s};
        end
        if (sck_fall && hdr[HW-1]) begin
          if (cnt == CW'(HW) && !rb_active) begin
            ob <= (hdr[AW-1:0] == '0) ? ID_VAL[DW-1:0] : rd_data;
            rb_active <= 1'b1;
          end else if (cnt == CW'(FW)) begin
            rb_active <= 1'b0;
          end else if (rb_active) begin
            ob <= {ob[DW-2:0], 1'b0};
          end
        end
      end
    end
  end

  assign drv   = rb_active & ~cs_s;
  assign bit_o = ob[DW-1];
  assign out_o = cfg_odrain ? 1'b0 : bit_o;
  assign oe_o  = cfg_odrain ? (drv & ~bit_o) : drv;

  assign sdio_out  = cfg_rb3w ? out_o : 1'b0;
  assign sdio_oe   = cfg_rb3w ? oe_o  : 1'b0;
  assign sdout_out = cfg_rb3w ? 1'b0  : out_o;
  assign sdout_oe  = cfg_rb3w ? 1'b0  : oe_o;
endmodule

// File: rtl/spi_regport_chk.sv
module spi_regport_chk (
  input logic clk,
  input logic rst_n,
  input logic por_active,
  input logic cfg_odrain,
  input logic csb,
  input logic sdio_out,
  input logic sdio_oe,
  input logic sdout_out,
  input logic sdout_oe,
  input logic wr_stb,
  input logic soft_rst
);
  AST_STB_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n) wr_stb |=> !wr_stb); // R2
  AST_RST_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n) soft_rst |=> !soft_rst); // R2
  AST_STB_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n) !(wr_stb && soft_rst)); // R7
  AST_POR_BLOCKS_WR: assert property (@(posedge clk) disable iff (!rst_n) (wr_stb || soft_rst) |-> !$past(por_active)); // R8
  AST_ONE_PIN_ONLY:  assert property (@(posedge clk) disable iff (!rst_n) !(sdio_oe && sdout_oe)); // R9
  AST_DRAIN_LOW_3W:  assert property (@(posedge clk) disable iff (!rst_n) (cfg_odrain && sdio_oe) |-> !sdio_out); // R10
  AST_DRAIN_LOW_4W:  assert property (@(posedge clk) disable iff (!rst_n) (cfg_odrain && sdout_oe) |-> !sdout_out); // R10
  AST_IDLE_UNDRIVEN: assert property (@(posedge clk) disable iff (!rst_n)
    (csb && $past(csb) && $past(csb, 2) && $past(csb, 3)) |-> (!sdio_oe && !sdout_oe)); // R11
endmodule

bind spi_regport spi_regport_chk u_chk (
  .clk(clk), .rst_n(rst_n), .por_active(por_active), .cfg_odrain(cfg_odrain),
  .csb(csb), .sdio_out(sdio_out), .sdio_oe(sdio_oe), .sdout_out(sdout_out),
  .sdout_oe(sdout_oe), .wr_stb(wr_stb), .soft_rst(soft_rst)
);

// File: tb/sim_spi_regport.sv
`timescale 1ns/1ps
module sim_spi_regport;
  logic clk = 1'b0, rst_n = 1'b0;
  logic por_active = 1'b0, cfg_rb3w = 1'b1, cfg_odrain = 1'b0;
  logic csb = 1'b1, sclk = 1'b0, sdin = 1'b0;
  logic sdio_out, sdio_oe, sdout_out, sdout_oe, wr_stb, soft_rst;
  logic [6:0] rd_addr, wr_addr;
  logic [15:0] rd_data, wr_data;

  int checks = 0, fails = 0, n_wr = 0, n_sr = 0, wide = 0, cyc = 0;
  logic [6:0] cap_a;
  logic [15:0] cap_d;
  logic prev_wr = 1'b0, prev_sr = 1'b0;
  logic [15:0] got;
  logic bad_pin, bad_oe;

  always #5 clk = ~clk;

  function automatic logic [15:0] regval(input logic [6:0] a);
    return {a, a ^ 7'h5A, 2'b10};
  endfunction
  function automatic logic [15:0] expect_rd(input logic [6:0] a);
    return (a == 7'd0) ? 16'h8990 : regval(a);
  endfunction
  assign rd_data = regval(rd_addr);

  spi_regport u0 (.*);

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (wr_stb) begin n_wr <= n_wr + 1; cap_a <= wr_addr; cap_d <= wr_data; end
    if (soft_rst) n_sr <= n_sr + 1;
    if ((wr_stb && prev_wr) || (soft_rst && prev_sr) || (wr_stb && soft_rst)) wide <= wide + 1;
    prev_wr <= wr_stb; prev_sr <= soft_rst;
    if (cyc > 150000) begin
      fails = fails + 1;
      $display("FAIL watchdog: act=%0d exp<=150000 cycles", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  task automatic chk(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic wclk(input int n);
    repeat (n) @(posedge clk);
  endtask

  task automatic frame(input logic rw, input logic [6:0] a, input logic [15:0] d, input int nbits);
    logic [23:0] w;
    logic obs, oe, oe_other, outv;
    w = {rw, a, d};
    got = '0; bad_pin = 1'b0; bad_oe = 1'b0;
    csb = 1'b0;
    wclk(4);
    for (int i = 0; i < nbits; i++) begin
      sdin = (i < 24) ? w[23-i] : ~w[0];
      wclk(4);
      @(negedge clk);
      oe = cfg_rb3w ? sdio_oe : sdout_oe;
      outv = cfg_rb3w ? sdio_out : sdout_out;
      oe_other = cfg_rb3w ? sdout_oe : sdio_oe;
      if (oe_other) bad_pin = 1'b1;
      if (i >= 8 && i < 24 && rw) begin
        obs = cfg_odrain ? ~oe : outv;
        if (!cfg_odrain && !oe) bad_oe = 1'b1;
        if (cfg_odrain && oe && outv) bad_oe = 1'b1;
        got[23-i] = obs;
      end else if (oe) bad_oe = 1'b1;
      sclk = 1'b1;
      wclk(4);
      sclk = 1'b0;
    end
    wclk(4);
    csb = 1'b1;
    wclk(12);
  endtask

  task automatic do_write(input logic [6:0] a, input logic [15:0] d, input int nbits, input string tag);
    int w0, s0;
    w0 = n_wr; s0 = n_sr;
    frame(1'b0, a, d, nbits);
    if (nbits < 24 || por_active) begin
      chk(n_wr == w0 && n_sr == s0, tag, n_wr - w0 + n_sr - s0, 0);
    end else if (a == 0) begin
      chk(n_sr == s0 + 1 && n_wr == w0, {tag, " R7"}, {n_sr - s0, n_wr - w0}, {32'd1, 32'd0});
    end else begin
      chk(n_wr == w0 + 1 && n_sr == s0, {tag, " R1 count"}, n_wr - w0, 1);
      chk(cap_a == a && cap_d == d, {tag, " R1 fields"}, {cap_a, cap_d}, {a, d});
    end
    chk(!bad_oe && !bad_pin, "R11 write frame undriven", {bad_oe, bad_pin}, 0);
  endtask

  task automatic do_read(input logic [6:0] a, input logic od, input logic w3);
    cfg_odrain = od; cfg_rb3w = w3;
    frame(1'b1, a, 16'h0000, 24);
    chk(got == expect_rd(a), (a == 0) ? "R6 id read" : "R5 read data", got, expect_rd(a));
    chk(!bad_pin, "R9 unselected pin idle", bad_pin, 0);
    chk(!bad_oe, "R10 drive style", bad_oe, 0);
    chk(!sdio_oe && !sdout_oe, "R11 idle after frame", {sdio_oe, sdout_oe}, 0);
  endtask

  initial begin
    void'($urandom(1234));
    wclk(3);
    rst_n = 1'b1;
    wclk(2);
    @(negedge clk);
    chk(!wr_stb && !soft_rst && !sdio_oe && !sdout_oe, "R11 reset state", {wr_stb, soft_rst, sdio_oe, sdout_oe}, 0);

    do_write(7'h15, 16'hA5C3, 24, "R1 basic");
    do_write(7'h7F, 16'hFFFF, 24, "R1 all ones");
    do_write(7'h01, 16'h0001, 24, "R1 low");
    do_write(7'h22, 16'h1234, 23, "R3 short 23");
    do_write(7'h22, 16'h1234, 5, "R3 short 5");
    do_write(7'h33, 16'h8001, 27, "R4 extra bits");
    do_write(7'h00, 16'hDEAD, 24, "R7 reg0");
    por_active = 1'b1;
    do_write(7'h44, 16'h4444, 24, "R8 por blocks write");
    do_write(7'h00, 16'h4444, 24, "R8 por blocks reset");
    por_active = 1'b0;
    do_write(7'h44, 16'h4444, 24, "R8 after por");

    do_read(7'h00, 1'b0, 1'b1);
    do_read(7'h00, 1'b1, 1'b0);
    do_read(7'h2B, 1'b0, 1'b1);
    do_read(7'h2B, 1'b1, 1'b1);
    do_read(7'h55, 1'b0, 1'b0);
    do_read(7'h55, 1'b1, 1'b0);

    for (int k = 0; k < 30; k++) begin
      logic rw;
      logic [6:0] a;
      logic [15:0] d;
      rw = $urandom_range(0, 1);
      a = 7'($urandom);
      d = 16'($urandom);
      if (rw) do_read(a, 1'($urandom), 1'($urandom));
      else do_write(a, d, 24, "R1 random");
    end

    chk(wide == 0, "R2 single-cycle strobes", wide, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule